// File: doc/BRIEF.md
# Programmable-logic output macrocell bank

This block is the output stage that sits after the product-term array of a small fuse-programmed logic device. It holds ten output cells. Each cell receives the OR-sum of its product terms and its own preset term. All cells share one global clear term and one global drive-enable term. A packed 20-bit configuration word chooses each cell's behaviour. A cell either passes its sum straight through as combinational logic, or it captures the sum in a D register on the rising edge of the device clock. Most cells also have an optional output inversion.

Every cell returns a feedback value to the array. A combinational cell returns its pin value. A registered cell returns the raw register contents, taken before any inversion. With this feedback path the array can build counters and state machines from registered cells. The bank is built from the fuse-loaded configuration word and the array outputs, and it drives the pin values together with their drive enables.

Cell index k serves device pin 23−k, so cell 0 is pin 23 and cell 9 is pin 14. The configuration word keeps the fuse order of the device: bit 0 is the sync flag and bit 1 is the global combinational flag. Bits 2+k hold the mode of cell k. Bits 12+k hold the inversion of cell k, for k from 0 to 7 only.

Top module: `mcell_bank`

## Requirements
- R1: Bit 2+k of `cfg_word` sets the mode of cell k (k = 0 is pin 23, k = 9 is pin 14). A value of 1 selects combinational mode and 0 selects registered mode. Each mode bit acts only on its own cell.
- R2: In combinational mode, `pin_q[k]` equals `sum_in[k]` XOR the cell's inversion bit in the same cycle, with no clock edge needed.
- R3: In registered mode, the cell loads `sum_in[k]` on each rising `clk` edge. Between edges a change on `sum_in` does not reach `fb_out` or `pin_q`.
- R4: Bit 12+k of `cfg_word` (k = 0..7) inverts the pin of cell k when it is 1. Cells 8 and 9 have no inversion bit and are always active-high.
- R5: While `rst_term` is 1, every register clears to 0 at once, without waiting for a clock edge. It stays 0 across clock edges even when the preset term or the sum is 1.
- R6: In registered mode, `preset_in[k]` = 1 at a rising edge loads 1 instead of the sum. In combinational mode the preset term has no effect.
- R7: `fb_out[k]` equals the pin value for a combinational cell and the non-inverted register value for a registered cell. A cell in combinational mode keeps its register contents.
- R8: Every bit of `pin_en` follows `oe_term`.
- R9: Bits 0 and 1 of `cfg_word` (the sync flag and the global combinational flag) have no effect on any output.
- R10: A registered cell whose sum is driven with the complement of its own feedback toggles on every rising edge, starting from 0 after a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock; registered cells sample on its rising edge |
| rst_term | input | 1 | Global clear product term, asynchronous, active-high |
| oe_term | input | 1 | Global drive-enable product term |
| cfg_word | input | 20 | Packed configuration: sync flag, global combinational flag, ten mode bits, eight inversion bits |
| sum_in | input | 10 | OR-sum of each cell's product terms, bit k for cell k |
| preset_in | input | 10 | Synchronous preset product term per cell |
| pin_q | output | 10 | Pin value per cell, after inversion |
| pin_en | output | 10 | Drive enable per pin |
| fb_out | output | 10 | Feedback into the array per cell |

## Verification
The bench checks the places where a design could mix up one cell's bits with another's. It sets mixed modes and inversion patterns in which a swapped mode bit or inversion bit would show as a wrong pin on exactly one cell. It also checks that pins 15 and 14 never invert, even though the bits that follow their slots in the word are set. It asserts the clear together with an active preset and a rising edge: a design that gave preset priority, or that waited for the clock to clear, would show 1s or a stale value on the feedback. It also switches a loaded registered cell to combinational mode and back without an edge. A design that took the feedback after inversion, or that let the register load while in combinational mode, would return the wrong feedback bits.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    // Default bank geometry
    localparam int NCELL_DEF = 10;   // output cells
    localparam int NINV_DEF  = 8;    // cells that own an inversion bit
    localparam int GLOB_W    = 2;    // sync flag + global combinational flag
    localparam int MODE_LSB  = GLOB_W;

    typedef enum logic {
        MODE_REG  = 1'b0,
        MODE_COMB = 1'b1
    } cell_mode_e;

    typedef struct packed {
        cell_mode_e mode;
        logic       invert;
    } cell_cfg_t;

    function automatic int cfg_width(input int ncell, input int ninv);
        return GLOB_W + ncell + ninv;
    endfunction

    function automatic cell_cfg_t make_cell_cfg(input logic mode_bit,
                                                input logic inv_bit);
        cell_cfg_t c;
        c.mode   = mode_bit ? MODE_COMB : MODE_REG;
        c.invert = inv_bit;
        return c;
    endfunction

endpackage

// File: rtl/mcell_cfg_unpack.sv
module mcell_cfg_unpack
    import mcell_pkg::*;
#(
    parameter int N_CELL = NCELL_DEF,
    parameter int N_INV  = NINV_DEF,
    localparam int CFG_W   = GLOB_W + N_CELL + N_INV,
    localparam int INV_LSB = MODE_LSB + N_CELL
) (
    input  logic [CFG_W-1:GLOB_W]   cell_bits,
    output cell_cfg_t [N_CELL-1:0]  cell_cfg
);

    for (genvar k = 0; k < N_CELL; k++) begin : g_cell
        if (k < N_INV) begin : g_inv
            assign cell_cfg[k] = make_cell_cfg(cell_bits[MODE_LSB + k],
                                               cell_bits[INV_LSB + k]);
        end else begin : g_fixed
            assign cell_cfg[k] = make_cell_cfg(cell_bits[MODE_LSB + k], 1'b0);
        end
    end

endmodule

// File: rtl/mcell_slice.sv
module mcell_slice
    import mcell_pkg::*;
(
    input  logic      clk,
    input  logic      clr_async,
    input  logic      en_term,
    input  cell_cfg_t cfg,
    input  logic      sum,
    input  logic      preset,
    output logic      pin,
    output logic      en,
    output logic      fb
);

    logic q;
    logic pre_pol;

    // Register holds its contents while the cell is combinational
    always_ff @(posedge clk or posedge clr_async) begin
        if (clr_async) begin
            q <= 1'b0;
        end else if (cfg.mode == MODE_REG) begin
            q <= preset ? 1'b1 : sum;
        end
    end

    always_comb begin
        pre_pol = (cfg.mode == MODE_COMB) ? sum : q;
        pin     = pre_pol ^ cfg.invert;
        fb      = (cfg.mode == MODE_COMB) ? pin : q;
        en      = en_term;
    end

endmodule

// File: rtl/mcell_bank.sv
module mcell_bank
    import mcell_pkg::*;
#(
    parameter int N_CELL = NCELL_DEF,
    parameter int N_INV  = NINV_DEF,
    localparam int CFG_W = GLOB_W + N_CELL + N_INV
) (
    input  logic              clk,
    input  logic              rst_term,
    input  logic              oe_term,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [N_CELL-1:0] sum_in,
    input  logic [N_CELL-1:0] preset_in,
    output logic [N_CELL-1:0] pin_q,
    output logic [N_CELL-1:0] pin_en,
    output logic [N_CELL-1:0] fb_out
);

    cell_cfg_t [N_CELL-1:0] cell_cfg;

    // Global flags (cfg_word[1:0]) do not steer any cell
    mcell_cfg_unpack #(
        .N_CELL (N_CELL),
        .N_INV  (N_INV)
    ) u_unpack (
        .cell_bits (cfg_word[CFG_W-1:GLOB_W]),
        .cell_cfg  (cell_cfg)
    );

    for (genvar k = 0; k < N_CELL; k++) begin : g_slice
        mcell_slice u_slice (
            .clk       (clk),
            .clr_async (rst_term),
            .en_term   (oe_term),
            .cfg       (cell_cfg[k]),
            .sum       (sum_in[k]),
            .preset    (preset_in[k]),
            .pin       (pin_q[k]),
            .en        (pin_en[k]),
            .fb        (fb_out[k])
        );
    end

endmodule

// File: rtl/mcell_bank_chk.sv
module mcell_bank_chk
    import mcell_pkg::*;
#(
    parameter int N_CELL = NCELL_DEF,
    parameter int N_INV  = NINV_DEF,
    localparam int CFG_W   = GLOB_W + N_CELL + N_INV,
    localparam int INV_LSB = MODE_LSB + N_CELL
) (
    input logic              clk,
    input logic              rst_term,
    input logic              oe_term,
    input logic [CFG_W-1:0]  cfg_word,
    input logic [N_CELL-1:0] sum_in,
    input logic [N_CELL-1:0] preset_in,
    input logic [N_CELL-1:0] pin_q,
    input logic [N_CELL-1:0] pin_en,
    input logic [N_CELL-1:0] fb_out
);

    always @(negedge clk) begin
        p_enable_follow_r8: assert (pin_en == {N_CELL{oe_term}})
            else $error("pin_en does not follow oe_term");
    end

    for (genvar k = 0; k < N_CELL; k++) begin : g_chk
        logic inv_k;
        logic comb_k;
        if (k < N_INV) begin : g_i
            assign inv_k = cfg_word[INV_LSB + k];
        end else begin : g_f
            assign inv_k = 1'b0;
        end
        assign comb_k = cfg_word[MODE_LSB + k];

        always @(negedge clk) begin
            if (comb_k) begin
                p_comb_pass_r2: assert (pin_q[k] == (sum_in[k] ^ inv_k))
                    else $error("combinational pin mismatch");
                p_comb_feedback_r7: assert (fb_out[k] == pin_q[k])
                    else $error("combinational feedback mismatch");
            end else begin
                p_reg_polarity_r4: assert (pin_q[k] == (fb_out[k] ^ inv_k))
                    else $error("registered pin polarity mismatch");
                if (rst_term) begin
                    p_async_clear_r5: assert (fb_out[k] == 1'b0)
                        else $error("register not cleared");
                end
            end
        end

        p_reg_load_r3: assert property (@(posedge clk) disable iff (rst_term)
            (!comb_k && !preset_in[k]) |=> (comb_k || fb_out[k] == $past(sum_in[k])))
            else $error("register did not load sum");

        p_preset_one_r6: assert property (@(posedge clk) disable iff (rst_term)
            (!comb_k && preset_in[k]) |=> (comb_k || fb_out[k]))
            else $error("preset did not load one");

        p_global_bits_inert_r9: assert property (@(posedge clk) disable iff (rst_term)
            ((cfg_word[1:0] != $past(cfg_word[1:0])) &&
             (cfg_word[CFG_W-1:GLOB_W] == $past(cfg_word[CFG_W-1:GLOB_W])) &&
             (sum_in == $past(sum_in)) && comb_k)
            |-> (pin_q[k] == $past(pin_q[k])))
            else $error("global flag changed a pin");
    end

endmodule

bind mcell_bank mcell_bank_chk #(
    .N_CELL (N_CELL),
    .N_INV  (N_INV)
) u_chk (.*);

// File: tb/mcell_bank_test.sv
`timescale 1ns/100ps
module mcell_bank_test;

    localparam int NC = 10;
    localparam int CW = 20;

    logic          clk = 1'b0;
    logic          rst_term;
    logic          oe_term;
    logic [CW-1:0] cfg_word;
    logic [NC-1:0] sum_in;
    logic [NC-1:0] preset_in;
    logic [NC-1:0] pin_q;
    logic [NC-1:0] pin_en;
    logic [NC-1:0] fb_out;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    mcell_bank uut (
        .clk       (clk),
        .rst_term  (rst_term),
        .oe_term   (oe_term),
        .cfg_word  (cfg_word),
        .sum_in    (sum_in),
        .preset_in (preset_in),
        .pin_q     (pin_q),
        .pin_en    (pin_en),
        .fb_out    (fb_out)
    );

    typedef struct packed {
        logic [7:0] inv;
        logic [9:0] comb;
        logic [1:0] glob;
        logic [9:0] sum;
        logic [9:0] pre;
        logic       oe;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h00, 10'h3FF, 2'b11, 10'h000, 10'h000, 1'b1},
        '{8'hFF, 10'h3FF, 2'b00, 10'h000, 10'h3FF, 1'b0},
        '{8'h5A, 10'h3FF, 2'b01, 10'h2C3, 10'h155, 1'b1},
        '{8'h00, 10'h0F0, 2'b10, 10'h3FF, 10'h000, 1'b1},
        '{8'h81, 10'h00F, 2'b11, 10'h1A5, 10'h00F, 1'b0},
        '{8'h3C, 10'h300, 2'b00, 10'h200, 10'h300, 1'b1},
        '{8'hFF, 10'h3FF, 2'b10, 10'h3FF, 10'h000, 1'b1},
        '{8'h0F, 10'h2AA, 2'b01, 10'h0CC, 10'h3FF, 1'b1}
    };

    function automatic logic [CW-1:0] mkcfg(input logic [7:0] inv,
                                            input logic [9:0] comb,
                                            input logic [1:0] glob);
        return {inv, comb, glob};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [NC-1:0] act, input logic [NC-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive point: 0.5 ns after a falling edge
    task automatic drive_slot();
        @(negedge clk);
        #0.5;
    endtask

    // from a drive point, cross one rising edge and land at a check point
    task automatic edge_then_check();
        @(negedge clk);
        #2;
    endtask

    initial begin
        rst_term  = 1'b1;
        oe_term   = 1'b0;
        cfg_word  = mkcfg(8'h00, 10'h000, 2'b00);
        sum_in    = '1;
        preset_in = '1;
        repeat (3) @(negedge clk);
        #2;
        // R5 reset state: registers cleared despite sum and preset held high
        check("R5", "reset fb", fb_out, 10'h000);
        check("R5", "reset pin", pin_q, 10'h000);
        check("R8", "enable low", pin_en, 10'h000);

        drive_slot();
        rst_term  = 1'b0;
        preset_in = '0;
        sum_in    = '0;

        // Table walk: combinational cells only (R2, R4, R6, R7, R8, R9)
        for (int i = 0; i < 8; i++) begin
            logic [9:0] exp;
            drive_slot();
            cfg_word  = mkcfg(VECS[i].inv, VECS[i].comb, VECS[i].glob);
            sum_in    = VECS[i].sum;
            preset_in = VECS[i].pre;
            oe_term   = VECS[i].oe;
            #1.5;
            exp = (VECS[i].sum ^ {2'b00, VECS[i].inv}) & VECS[i].comb;
            check("R2", $sformatf("vec%0d pin", i), pin_q & VECS[i].comb, exp);
            check("R7", $sformatf("vec%0d fb", i), fb_out & VECS[i].comb, exp);
            check("R8", $sformatf("vec%0d en", i), pin_en, {NC{VECS[i].oe}});
        end

        // AND / OR gate through cells 0 and 1 (R2)
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                logic la, lb;
                la = 1'(a);
                lb = 1'(b);
                drive_slot();
                cfg_word  = mkcfg(8'h00, 10'h3FF, 2'b00);
                preset_in = '0;
                sum_in    = {8'h00, la | lb, la & lb};
                #1.5;
                check("R2", $sformatf("gate a=%0d b=%0d", a, b),
                      pin_q, {8'h00, la | lb, la & lb});
            end
        end

        // R1: only cell 0 (pin 23) combinational; others hold cleared registers
        drive_slot();
        rst_term = 1'b1;
        drive_slot();
        rst_term = 1'b0;
        cfg_word = mkcfg(8'h00, 10'h001, 2'b00);
        sum_in   = '1;
        #1.5;
        check("R1", "single comb cell", pin_q, 10'h001);

        // R3/R4: registered load with inversion pattern
        drive_slot();
        rst_term = 1'b1;
        drive_slot();
        rst_term = 1'b0;
        cfg_word = mkcfg(8'hA5, 10'h000, 2'b00);
        sum_in   = 10'h35A;
        #1.5;
        check("R3", "no load before edge", fb_out, 10'h000);
        edge_then_check();
        check("R3", "load after edge", fb_out, 10'h35A);
        check("R4", "inverted reg pin", pin_q, 10'h35A ^ 10'h0A5);

        // R6: preset loads ones
        drive_slot();
        sum_in    = 10'h000;
        preset_in = 10'h0F0;
        edge_then_check();
        check("R6", "preset load", fb_out, 10'h0F0);

        // R5: clear is immediate and beats preset across an edge
        drive_slot();
        preset_in = '1;
        sum_in    = '1;
        rst_term  = 1'b1;
        #1;
        check("R5", "async clear", fb_out, 10'h000);
        edge_then_check();
        check("R5", "clear beats preset", fb_out, 10'h000);
        drive_slot();
        rst_term  = 1'b0;
        preset_in = '0;
        sum_in    = '0;
        cfg_word  = mkcfg(8'h00, 10'h000, 2'b00);

        // R10: toggle via feedback
        for (int n = 1; n <= 6; n++) begin
            drive_slot();
            sum_in = ~fb_out;
            edge_then_check();
            check("R10", $sformatf("toggle %0d", n), fb_out,
                  (n % 2 == 1) ? 10'h3FF : 10'h000);
        end

        // R7: mode switch without edge keeps register, feedback follows pin
        drive_slot();
        sum_in = 10'h3FF;
        edge_then_check();
        drive_slot();
        cfg_word = mkcfg(8'hFF, 10'h3FF, 2'b00);
        sum_in   = 10'h000;
        edge_then_check();
        check("R7", "comb fb is pin", fb_out, 10'h0FF);
        check("R4", "no invert on cells 8,9", pin_q & 10'h300, 10'h000);
        drive_slot();
        cfg_word = mkcfg(8'hFF, 10'h000, 2'b00);
        #1.5;
        check("R7", "register held in comb mode", fb_out, 10'h3FF);
        check("R4", "reg pin inverted on 0..7", pin_q, 10'h300);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule